// File: doc/BRIEF.md
# Stall-Only Pipeline Hazard Interlock

This block detects read-after-write conflicts in a five-stage in-order pipeline that has no bypass network. Each cycle it takes the two source register names of the instruction waiting in decode, together with a flag per source saying whether the operand is really read. It compares them against the destination names and write enables of the two older instructions that are still in the execute and memory stages. If any live comparison matches, the unit holds the program counter and the fetch/decode register. It also loads a bubble into the decode/execute register: every control bit is cleared and the write enable is dropped.

The block contains a cycle-accurate model of the destination-tracking part of the decode/execute and execute/memory registers, so the stall is derived from the same state a real pipeline would carry. A producer that is one instruction ahead costs two bubbles. A producer that is two ahead costs one bubble. A producer already in write-back costs nothing, because the register file writes in the first half of the cycle and reads in the second half. No bubble counter is kept: the comparison is repeated every cycle while the older instruction moves forward.

Top module: `hazard_interlock`

## Requirements
- R1: While `rst` is high and after it falls, the tracked decode/execute and execute/memory entries are empty: `idex_ctrl` is zero and no stall is raised until a writing instruction has been issued.
- R2: When the decode/execute entry writes a register that a used decode source names, the consumer is stalled for exactly two consecutive cycles, provided decode inputs are held.
- R3: When only the execute/memory entry writes a register that a used decode source names, the consumer is stalled for exactly one cycle.
- R4: A producer three instructions ahead (already in write-back) causes no stall.
- R5: A comparison never matches when the older entry's write enable is 0 or its destination is register 0.
- R6: A source whose use flag is 0 never causes a stall, whatever its register name.
- R7: In every stall cycle the decode/execute register is loaded with a bubble, so `idex_ctrl` reads all zeros in the following cycle.
- R8: `pc_hold` and `ifid_hold` are both 1 in exactly the cycles where a conflict is present, in the same cycle as the conflict and with no register delay.
- R9: In a cycle without stall, the decode/execute register captures `dec_ctrl`, `dec_rd` and `dec_wen`. The execute/memory entry always takes the previous decode/execute entry.
- R10: Either source may match either watched stage, and both may match at once. When sources match both stages at the same time, the stall still lasts two cycles, because the comparison is repeated every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | REG_AW | First source register name in decode |
| dec_rs2 | input | REG_AW | Second source register name in decode |
| dec_use_rs1 | input | 1 | First source is actually read |
| dec_use_rs2 | input | 1 | Second source is actually read |
| dec_rd | input | REG_AW | Destination register name of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes its destination |
| dec_ctrl | input | CTRL_W | Control bits produced by decode |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_ctrl | output | CTRL_W | Control bits held in the decode/execute register |

## Verification
The bench uses the default values: 5-bit register names, 32 architectural registers with register 0 hard-wired, and 8 control bits. A nonzero consumer control pattern therefore makes a bubble easy to tell apart from an issued instruction. The small name space lets the directed scenarios reach the corner cases. These cases are register 0 as a destination, matches on the first and on the second source, and two producers placed back to back so that both watched stages match at once. Stall lengths are counted by holding the consumer in decode until the hold is released, so a wrong count of bubbles shows up directly.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // number of source operands compared per decode instruction
  localparam int unsigned SRC_PORTS    = 2;
  // number of older pipeline stages watched for producers
  localparam int unsigned WATCH_STAGES = 2;

  typedef enum int unsigned {
    WATCH_IDEX  = 0,
    WATCH_EXMEM = 1
  } watch_stage_e;
endpackage

// File: rtl/hz_compare.sv
module hz_compare #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSRC   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0][REG_AW-1:0] src_name,
  input  logic [NSRC-1:0]            src_used,
  input  logic [REG_AW-1:0]          old_rd,
  input  logic                       old_wen,
  output logic                       hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic             dest_live;
  logic [NSRC-1:0]  per_src;

  assign dest_live = old_wen && (old_rd != ZERO_REG);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign per_src[s] = src_used[s] && (src_name[s] == old_rd);
  end

  assign hit = dest_live && (|per_src);

  // R5: a match requires a writing older instruction with a nonzero destination
  assert_live_dest_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (old_wen && old_rd != ZERO_REG));
endmodule

// File: rtl/hz_track.sv
module hz_track #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bubble,
  input  logic [REG_AW-1:0] dec_rd,
  input  logic              dec_wen,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic [REG_AW-1:0] idex_rd,
  output logic              idex_wen,
  output logic [CTRL_W-1:0] idex_ctrl,
  output logic [REG_AW-1:0] exmem_rd,
  output logic              exmem_wen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idex_rd   <= '0;
      idex_wen  <= 1'b0;
      idex_ctrl <= '0;
      exmem_rd  <= '0;
      exmem_wen <= 1'b0;
    end else begin
      exmem_rd  <= idex_rd;
      exmem_wen <= idex_wen;
      if (bubble) begin
        idex_rd   <= '0;
        idex_wen  <= 1'b0;
        idex_ctrl <= '0;
      end else begin
        idex_rd   <= dec_rd;
        idex_wen  <= dec_wen;
        idex_ctrl <= dec_ctrl;
      end
    end
  end

  // R7: a stall cycle leaves an all-zero entry behind it
  assert_bubble_zero_R7: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (idex_ctrl == '0 && !idex_wen));

  // R9: without a stall the decode fields are taken over
  assert_issue_load_R9: assert property (@(posedge clk) disable iff (rst)
    !bubble |=> (idex_rd == $past(dec_rd) && idex_ctrl == $past(dec_ctrl)
                 && idex_wen == $past(dec_wen)));

  // R9: the memory-stage entry follows the execute-stage entry
  assert_shift_mem_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (exmem_rd == $past(idex_rd) && exmem_wen == $past(idex_wen)));
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic              dec_use_rs1,
  input  logic              dec_use_rs2,
  input  logic [REG_AW-1:0] dec_rd,
  input  logic              dec_wen,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic [CTRL_W-1:0] idex_ctrl
);
  import hz_pkg::*;

  localparam int unsigned NSRC = SRC_PORTS;
  localparam int unsigned NSTG = WATCH_STAGES;

  logic [NSRC-1:0][REG_AW-1:0] src_name;
  logic [NSRC-1:0]             src_used;
  logic [NSTG-1:0][REG_AW-1:0] stg_rd;
  logic [NSTG-1:0]             stg_wen;
  logic [NSTG-1:0]             stg_hit;
  logic                        conflict;

  logic [REG_AW-1:0] idex_rd, exmem_rd;
  logic              idex_wen, exmem_wen;

  assign src_name[0] = dec_rs1;
  assign src_name[1] = dec_rs2;
  assign src_used[0] = dec_use_rs1;
  assign src_used[1] = dec_use_rs2;

  assign stg_rd[WATCH_IDEX]   = idex_rd;
  assign stg_wen[WATCH_IDEX]  = idex_wen;
  assign stg_rd[WATCH_EXMEM]  = exmem_rd;
  assign stg_wen[WATCH_EXMEM] = exmem_wen;

  for (genvar g = 0; g < NSTG; g++) begin : g_watch
    hz_compare #(.REG_AW(REG_AW), .NSRC(NSRC)) cmp_i (
      .clk      (clk),
      .rst      (rst),
      .src_name (src_name),
      .src_used (src_used),
      .old_rd   (stg_rd[g]),
      .old_wen  (stg_wen[g]),
      .hit      (stg_hit[g])
    );
  end

  assign conflict  = |stg_hit;
  assign pc_hold   = conflict;
  assign ifid_hold = conflict;

  hz_track #(.REG_AW(REG_AW), .CTRL_W(CTRL_W)) track_i (
    .clk       (clk),
    .rst       (rst),
    .bubble    (conflict),
    .dec_rd    (dec_rd),
    .dec_wen   (dec_wen),
    .dec_ctrl  (dec_ctrl),
    .idex_rd   (idex_rd),
    .idex_wen  (idex_wen),
    .idex_ctrl (idex_ctrl),
    .exmem_rd  (exmem_rd),
    .exmem_wen (exmem_wen)
  );

  // R2: a producer found in execute is still live one stage later
  assert_ex_moves_R2: assert property (@(posedge clk) disable iff (rst)
    stg_hit[WATCH_IDEX] |=> (exmem_wen && exmem_rd != '0));

  // R8: holds only appear while a live producer sits in a watched stage
  assert_hold_cause_R8: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> ((idex_wen && idex_rd != '0) || (exmem_wen && exmem_rd != '0)));
endmodule

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb_top;
  localparam int unsigned AW = 5;
  localparam int unsigned CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] dec_rs1, dec_rs2, dec_rd;
  logic dec_use_rs1, dec_use_rs2, dec_wen;
  logic [CW-1:0] dec_ctrl;
  logic pc_hold, ifid_hold;
  logic [CW-1:0] idex_ctrl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hazard_interlock #(.REG_AW(AW), .CTRL_W(CW)) dut_i (
    .clk(clk), .rst(rst),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_use_rs1(dec_use_rs1), .dec_use_rs2(dec_use_rs2),
    .dec_rd(dec_rd), .dec_wen(dec_wen), .dec_ctrl(dec_ctrl),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_ctrl(idex_ctrl)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // producer or filler: no sources used, must never stall
  task automatic issue(int rd, bit wen, int ctrl);
    @(negedge clk);
    dec_rs1 = '0; dec_rs2 = '0; dec_use_rs1 = 1'b0; dec_use_rs2 = 1'b0;
    dec_rd = AW'(rd); dec_wen = wen; dec_ctrl = CW'(ctrl);
    #1;
    check("R8 no hold for sourceless issue", int'(pc_hold), 0);
    @(posedge clk);
  endtask

  task automatic flush();
    issue(0, 1'b0, 0);
    issue(0, 1'b0, 0);
    issue(0, 1'b0, 0);
  endtask

  // holds the consumer in decode until released; returns stall cycles
  task automatic consume(int rs1, bit u1, int rs2, bit u2, output int n);
    @(negedge clk);
    dec_rs1 = AW'(rs1); dec_rs2 = AW'(rs2);
    dec_use_rs1 = u1; dec_use_rs2 = u2;
    dec_rd = AW'(1); dec_wen = 1'b0; dec_ctrl = 8'hC3;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      #1;
      check("R8 ifid_hold tracks pc_hold", int'(ifid_hold), int'(pc_hold));
      if (!pc_hold) break;
      n++;
      @(posedge clk); #1;
      check("R7 bubble ctrl zero", int'(idex_ctrl), 0);
      @(negedge clk);
    end
    @(posedge clk); #1;
    check("R9 consumer ctrl issued", int'(idex_ctrl), 'hC3);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    dec_rs1 = '0; dec_rs2 = '0; dec_use_rs1 = 1'b0; dec_use_rs2 = 1'b0;
    dec_rd = '0; dec_wen = 1'b0; dec_ctrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 ctrl zero in reset", int'(idex_ctrl), 0);
    rst = 1'b0;
    dec_rs1 = AW'(5); dec_use_rs1 = 1'b1; dec_rs2 = AW'(0); dec_use_rs2 = 1'b1;
    #1;
    check("R1 no hold after reset", int'(pc_hold), 0);
    @(posedge clk);
  endtask

  task automatic t_adjacent();
    int n;
    flush();
    issue(7, 1'b1, 'h5A);
    #1 check("R9 producer ctrl loaded", int'(idex_ctrl), 'h5A);
    consume(7, 1'b1, 0, 1'b0, n);
    check("R2 adjacent producer bubbles", n, 2);
  endtask

  task automatic t_gap_one();
    int n;
    flush();
    issue(9, 1'b1, 'h11);
    issue(0, 1'b0, 0);
    consume(2, 1'b1, 9, 1'b1, n);
    check("R3 one-apart producer bubbles", n, 1);
  endtask

  task automatic t_writeback();
    int n;
    flush();
    issue(11, 1'b1, 'h22);
    issue(0, 1'b0, 0);
    issue(0, 1'b0, 0);
    consume(11, 1'b1, 11, 1'b1, n);
    check("R4 write-back producer no stall", n, 0);
  endtask

  task automatic t_dead_dest();
    int n;
    flush();
    issue(0, 1'b1, 'h33);
    consume(0, 1'b1, 0, 1'b1, n);
    check("R5 register zero destination", n, 0);
    flush();
    issue(12, 1'b0, 'h44);
    consume(12, 1'b1, 12, 1'b1, n);
    check("R5 write enable clear", n, 0);
  endtask

  task automatic t_unused();
    int n;
    flush();
    issue(13, 1'b1, 'h55);
    consume(13, 1'b0, 13, 1'b0, n);
    check("R6 unused sources ignored", n, 0);
  endtask

  task automatic t_both();
    int n;
    flush();
    issue(3, 1'b1, 'h66);
    issue(4, 1'b1, 'h77);
    consume(3, 1'b1, 4, 1'b1, n);
    check("R10 both stages match", n, 2);
    flush();
    issue(6, 1'b1, 'h12);
    issue(8, 1'b1, 'h34);
    consume(6, 1'b1, 0, 1'b0, n);
    check("R10 older match via rs1 only", n, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_adjacent();
    t_gap_one();
    t_writeback();
    t_dead_dest();
    t_unused();
    t_both();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule